// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block sits in front of the write engine of one EEPROM bank. It watches byte-write transactions, each an address and a data byte, and spots two magic command sequences. A three-byte unlock sequence authorises the data loads that follow it in the current write period, and it schedules protection to switch on. A six-byte sequence also authorises the following loads, and it schedules protection to switch off. Each command byte is flagged and is never passed on as data.

The protection state changes only when the write engine signals the end of a write period. It changes then even if no data byte followed the command. While protection is on, a load that is not preceded by the unlock sequence in the same period is refused. A page holds a limited number of loads per period. When more than one bank exists, each bank uses its own instance, so every bank keeps an independent state.

Top module: `wp_seq_detect`

## Requirements
- R1: After reset `prot_on` is 0, and a data load at any address other than a command byte gets `wr_permit`=1.
- R2: The unlock sequence is data AAh at address 05555h, then 55h at 02AAAh, then A0h at 05555h. Each of these bytes gives `cmd_byte`=1 and `wr_permit`=0. Data loads that follow in the same period get `wr_permit`=1, even while protected.
- R3: After a complete unlock sequence, `prot_on` stays unchanged until the period ends. It becomes 1 at the clock edge that samples `period_end`=1, even when no data byte followed the sequence.
- R4: While `prot_on`=1, a load not preceded by the unlock sequence in the current period gets `wr_permit`=0 and `cmd_byte`=0.
- R5: The disable sequence is AAh@05555h, 55h@02AAAh, 80h@05555h, AAh@05555h, 55h@02AAAh, 20h@05555h. All six bytes give `cmd_byte`=1 and `wr_permit`=0. Loads that follow in the same period are permitted. `prot_on` becomes 0 at the next period end and not before.
- R6: A write that does not match the next expected command byte aborts a partial sequence and is not flagged. It is treated as an ordinary load: it is permitted only if unprotected or already unlocked. Matching then restarts from the first byte (AAh@05555h).
- R7: At most PAGE_BYTES (default 128) data loads get `wr_permit`=1 per write period. Every load beyond that is refused.
- R8: `period_end` clears the unlocked state and any partial sequence. While protected, a load after the period end without a new unlock sequence is refused.
- R9: Addresses are compared on all ADDR_W (default 17) bits. AAh at 15555h is an ordinary load and not a command byte.
- R10: While `wr_valid`=0, both `wr_permit` and `cmd_byte` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; protection off |
| wr_valid | input | 1 | A byte-write transaction is present this cycle |
| wr_addr | input | ADDR_W | Transaction address |
| wr_data | input | 8 | Transaction data byte |
| period_end | input | 1 | Pulse from the write engine: the write period has ended |
| wr_permit | output | 1 | This transaction's data may be stored (combinational) |
| cmd_byte | output | 1 | This transaction is part of a command sequence (combinational) |
| prot_on | output | 1 | Current protection status |

## Verification
A wrong sequence position shows up at the ports at once. The very next command byte loses its `cmd_byte` flag, or an ordinary load gains it, in the same cycle it is presented. A wrong unlocked or pending state shows up in two ways: in the permit decision of the first data load after the sequence, and in `prot_on` one edge after `period_end`. A stale page count is caught by running a full page of loads and checking that exactly the 129th is refused.

// File: rtl/wp_seq_detect.sv
module wp_seq_detect #(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 128,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = ADDR_W'(17'h05555),
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = ADDR_W'(17'h02AAA)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              period_end,
  output logic              wr_permit,
  output logic              cmd_byte,
  output logic              prot_on
);
  localparam int CW = $clog2(PAGE_BYTES + 1);
  localparam logic [CW-1:0] PAGE_MAX = CW'(PAGE_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_O3, ST_O4, ST_O5
  } step_t;

  step_t         step, step_nx;
  logic          unlocked;
  logic          pend_vld, pend_val;
  logic [CW-1:0] loads;
  logic          hit, fin_on, fin_off, room;

  wire at_a = (wr_addr == KEY_ADDR_A);
  wire at_b = (wr_addr == KEY_ADDR_B);

  always_comb begin
    hit     = 1'b0;
    fin_on  = 1'b0;
    fin_off = 1'b0;
    step_nx = ST_IDLE;
    case (step)
      ST_IDLE: begin hit = at_a && wr_data == 8'hAA; step_nx = ST_K1; end
      ST_K1:   begin hit = at_b && wr_data == 8'h55; step_nx = ST_K2; end
      ST_K2: begin
        fin_on  = at_a && wr_data == 8'hA0;
        hit     = fin_on || (at_a && wr_data == 8'h80);
        step_nx = fin_on ? ST_IDLE : ST_O3;
      end
      ST_O3:   begin hit = at_a && wr_data == 8'hAA; step_nx = ST_O4; end
      ST_O4:   begin hit = at_b && wr_data == 8'h55; step_nx = ST_O5; end
      ST_O5: begin
        fin_off = at_a && wr_data == 8'h20;
        hit     = fin_off;
        step_nx = ST_IDLE;
      end
      default: ;
    endcase
  end

  assign room      = loads < PAGE_MAX;
  assign cmd_byte  = wr_valid && hit;
  assign wr_permit = wr_valid && !hit && room && (unlocked || !prot_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= ST_IDLE;
      unlocked <= 1'b0;
      pend_vld <= 1'b0;
      pend_val <= 1'b0;
      prot_on  <= 1'b0;
      loads    <= '0;
    end else if (period_end) begin
      if (pend_vld) prot_on <= pend_val;
      step     <= ST_IDLE;
      unlocked <= 1'b0;
      pend_vld <= 1'b0;
      loads    <= '0;
    end else if (wr_valid) begin
      if (hit) begin
        step <= step_nx;
        if (fin_on || fin_off) begin
          unlocked <= 1'b1;
          pend_vld <= 1'b1;
          pend_val <= fin_on;
        end
      end else begin
        step <= ST_IDLE;
        if (room) loads <= loads + 1'b1;
      end
    end
  end

  AST_CMD_NEVER_STORED: assert property (@(posedge clk) disable iff (!rst_n) cmd_byte |-> !wr_permit); // R2
  AST_PROT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n) !period_end |=> $stable(prot_on)); // R3
  AST_LOCKED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n) (wr_valid && prot_on && !unlocked) |-> !wr_permit); // R4
  AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) loads <= PAGE_MAX); // R7
  AST_END_DISARMS: assert property (@(posedge clk) disable iff (!rst_n) period_end |=> (!unlocked && step == ST_IDLE)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !wr_valid |-> (!wr_permit && !cmd_byte)); // R10
endmodule

// File: tb/wp_seq_detect_tb.sv
module wp_seq_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        period_end = 1'b0;
  logic        wr_permit, cmd_byte, prot_on;

  int n_vec = 0;
  int n_bad = 0;
  bit    qp[$];
  bit    qc[$];
  string qr[$];

  always #10 clk = ~clk;

  wp_seq_detect dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .period_end(period_end), .wr_permit(wr_permit),
    .cmd_byte(cmd_byte), .prot_on(prot_on)
  );

  always @(negedge clk) begin
    #5;
    if (wr_valid) begin
      if (qp.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL scoreboard: transaction seen with empty queue (actual 1 expected 0)");
      end else begin
        bit ep, ec;
        string r;
        ep = qp.pop_front(); ec = qc.pop_front(); r = qr.pop_front();
        n_vec++;
        if (wr_permit !== ep || cmd_byte !== ec) begin
          n_bad++;
          $display("FAIL %s: addr=%h data=%h permit/cmd actual=%b%b expected=%b%b",
                   r, wr_addr, wr_data, wr_permit, cmd_byte, ep, ec);
        end
      end
    end
  end

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input bit ep, input bit ec, input string r);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    qp.push_back(ep); qc.push_back(ec); qr.push_back(r);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    #5;
    n_vec++;
    if (wr_permit !== 1'b0 || cmd_byte !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: idle permit/cmd actual=%b%b expected=00", wr_permit, cmd_byte);
    end
  endtask

  task automatic end_period();
    @(negedge clk);
    wr_valid = 1'b0; period_end = 1'b1;
    @(negedge clk);
    period_end = 1'b0;
  endtask

  task automatic chk_prot(input bit e, input string r);
    #2;
    n_vec++;
    if (prot_on !== e) begin
      n_bad++;
      $display("FAIL %s: prot_on actual=%b expected=%b", r, prot_on, e);
    end
  endtask

  task automatic unlock(input string r);
    wr(17'h05555, 8'hAA, 0, 1, r);
    wr(17'h02AAA, 8'h55, 0, 1, r);
    wr(17'h05555, 8'hA0, 0, 1, r);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: run hung (actual timeout expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_prot(0, "R1");
    wr(17'h00100, 8'h12, 1, 0, "R1");
    idle();
    // R6 abort while unprotected: ordinary load, permitted
    wr(17'h05555, 8'hAA, 0, 1, "R6");
    wr(17'h00500, 8'h77, 1, 0, "R6");
    idle();
    end_period();
    chk_prot(0, "R6");
    // R2 / R3 unlock from unprotected
    unlock("R2");
    wr(17'h00200, 8'h34, 1, 0, "R2");
    idle();
    chk_prot(0, "R3");
    end_period();
    chk_prot(1, "R3");
    // R4 protected, no sequence
    wr(17'h00300, 8'h56, 0, 0, "R4");
    idle();
    end_period();
    chk_prot(1, "R4");
    // R3 unlock with no data still holds protection; R8 disarm at end
    unlock("R3");
    idle();
    end_period();
    chk_prot(1, "R3");
    wr(17'h00310, 8'h01, 0, 0, "R8");
    idle();
    // R2 unlock while protected then load; R8 cleared afterwards
    unlock("R2");
    wr(17'h00320, 8'h02, 1, 0, "R2");
    idle();
    end_period();
    wr(17'h00330, 8'h03, 0, 0, "R8");
    idle();
    // R6 abort while protected, then restart
    wr(17'h05555, 8'hAA, 0, 1, "R6");
    wr(17'h02AAA, 8'h55, 0, 1, "R6");
    wr(17'h00400, 8'h33, 0, 0, "R6");
    wr(17'h02AAA, 8'h55, 0, 0, "R6");
    unlock("R6");
    wr(17'h00410, 8'h44, 1, 0, "R6");
    idle();
    end_period();
    // R9 full address compare
    wr(17'h15555, 8'hAA, 0, 0, "R9");
    wr(17'h12AAA, 8'h55, 0, 0, "R9");
    idle();
    end_period();
    // R5 disable sequence
    wr(17'h05555, 8'hAA, 0, 1, "R5");
    wr(17'h02AAA, 8'h55, 0, 1, "R5");
    wr(17'h05555, 8'h80, 0, 1, "R5");
    wr(17'h05555, 8'hAA, 0, 1, "R5");
    wr(17'h02AAA, 8'h55, 0, 1, "R5");
    wr(17'h05555, 8'h20, 0, 1, "R5");
    wr(17'h00600, 8'h66, 1, 0, "R5");
    idle();
    chk_prot(1, "R5");
    end_period();
    chk_prot(0, "R5");
    wr(17'h00610, 8'h67, 1, 0, "R5");
    idle();
    end_period();
    // R7 page limit
    for (int i = 0; i < 130; i++)
      wr(17'(i), 8'h11, (i < 128), 0, "R7");
    idle();
    end_period();
    wr(17'h00700, 8'h22, 1, 0, "R7");
    idle();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule